// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero-Turnaround Protocol

This block is a synchronous single-port memory in which every enabled clock edge can take a new access. Reads and writes can alternate freely with no idle cycles between them. A read is flow-through: the word appears in the cycle that follows the edge that registered the read address. It passes through the array lookup and leaves with no output register. Write data arrives one enabled edge after its command. The block holds the write in a one-entry registry until the following enabled edge and forwards it to any read of the same word that comes in the meantime.

A loaded address can start a burst of four beats. On each later edge with the advance input high, the next beat uses the stored command and an address taken from a two-bit counter. The counter runs either in linear order or in interleaved order, and it wraps inside the aligned group of four. A clock-enable input freezes the whole block.

Three chip selects decide whether a load cycle starts an access. The output enable and a sleep input gate the drive-enable flag of the data output. The word is split into byte lanes, and each lane carries its own parity bit. Each lane has its own write enable.

Top module: `ftburst_sram`

## Requirements
- R1: An access is accepted on every enabled edge, so a write command, a read command and another write can follow on consecutive edges with no idle cycle, and each read returns the most recent data.
- R2: On an enabled edge with `advance`=0 and all `chip_sel` bits 1, the block registers `addr`, `write` and `interleave` as the start of a new burst, and that edge's access targets `addr`.
- R3: On an enabled edge with `advance`=1 during a burst, the access reuses the burst's command. The counter c advances (mod 4). The two low address bits become (start+c) mod 4 in linear order, or start XOR c in interleaved order. The upper bits stay unchanged, so the fifth beat returns to the start address.
- R4: After an edge that registers a read, `q` carries the stored word and `q_oe`=1 during the following cycle, provided `oe`=1.
- R5: Write data is taken from `wdata` at the next enabled edge after the write command's edge. Lane i is bits [i*LANE_W +: LANE_W], and this includes the parity bit. Lane i is written only when `byte_en[i]`=1 for that beat.
- R6: A write beat with `byte_en`=0 leaves memory unchanged. This holds for the first beat and for any later beat of a burst.
- R7: A read of a word whose write data has been taken but not yet committed returns the enabled lanes of the pending data, merged over the stored word.
- R8: An edge with `clk_en`=0 changes nothing: the burst state, the current access, `q` and `q_oe` hold, and `wdata` is not sampled.
- R9: A load cycle with any `chip_sel` bit 0 deselects the block: `q_oe` is 0 after that edge, and later advance cycles stay deselected until a selected load.
- R10: `oe`=0 forces `q_oe`=0 within the same cycle, with no clock edge.
- R11: While `sleep`=1, `q_oe` is 0, and each edge ends any burst whatever `clk_en` is. On leaving sleep, `q_oe` stays 0 until a new read is loaded.
- R12: After a synchronous reset, `q_oe`=0 and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = act on this edge, 0 = hold all state |
| chip_sel | input | NUM_SEL | Chip selects, all 1 to select on a load cycle |
| advance | input | 1 | 0 = load new address and command, 1 = next burst beat |
| write | input | 1 | Command on load cycles: 1 = write, 0 = read |
| addr | input | ADDR_W | Word address on load cycles |
| byte_en | input | LANES | Per-lane write enables for this beat |
| interleave | input | 1 | Burst order taken at load: 1 = interleaved, 0 = linear |
| oe | input | 1 | Output enable, combinational |
| sleep | input | 1 | Low-power request, deselects and blocks output |
| wdata | input | LANES*LANE_W | Write data, one enabled edge after its command |
| q | output | LANES*LANE_W | Read data, zero when not driving |
| q_oe | output | 1 | Drive enable for the tri-state data pins |

## Verification
The assertions assume three things about the inputs. The block is deselected, with no write beat in flight, before `sleep` rises. `interleave` matters only on load cycles. The write data for a beat is present at the next enabled edge, so stalls may fall between a command and its data. The stimulus deselects before every sleep interval and provides the data for each write on the following call. Where a stall is placed between a write and its data, it drives junk on `wdata` during the stalled edge to show that junk is ignored. Every location is filled before the first read, so every read has a defined expected word.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // Low two address bits of a burst beat, given start bits and beat count.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] cnt,
                                         input burst_ord_e ord);
    if (ord == ORD_INTERLEAVE) return start ^ cnt;
    return start + cnt;
  endfunction

endpackage

// File: rtl/ftb_ctl.sv
module ftb_ctl
  import ftb_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          sleep,
  input  logic          sel_ok,
  input  logic          advance,
  input  logic          we,
  input  logic          interleave,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] byte_en,
  output logic          acc_valid,
  output logic          acc_we,
  output logic [AW-1:0] acc_addr,
  output logic [NL-1:0] acc_be
);

  logic          brst_act;
  logic          brst_we;
  burst_ord_e    brst_ord;
  logic [AW-1:0] brst_base;
  logic [1:0]    brst_cnt;
  logic [1:0]    cnt_nxt;

  assign cnt_nxt = brst_cnt + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      brst_act  <= 1'b0;
      brst_we   <= 1'b0;
      brst_ord  <= ORD_LINEAR;
      brst_base <= '0;
      brst_cnt  <= '0;
      acc_valid <= 1'b0;
      acc_we    <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
    end else if (sleep) begin
      brst_act  <= 1'b0;
      acc_valid <= 1'b0;
    end else if (clk_en) begin
      if (!advance) begin
        brst_act  <= sel_ok;
        acc_valid <= sel_ok;
        if (sel_ok) begin
          brst_we   <= we;
          brst_ord  <= interleave ? ORD_INTERLEAVE : ORD_LINEAR;
          brst_base <= addr;
          brst_cnt  <= '0;
          acc_we    <= we;
          acc_addr  <= addr;
          acc_be    <= byte_en;
        end
      end else if (brst_act) begin
        brst_cnt  <= cnt_nxt;
        acc_valid <= 1'b1;
        acc_we    <= brst_we;
        acc_addr  <= {brst_base[AW-1:2], beat_lo(brst_base[1:0], cnt_nxt, brst_ord)};
        acc_be    <= byte_en;
      end else begin
        acc_valid <= 1'b0;
      end
    end
  end

  // R8: a disabled edge leaves the access and counter untouched
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !sleep) |=> ($stable(acc_valid) && $stable(acc_addr) && $stable(brst_cnt)));

  // R3: burst beats never leave the aligned group of four
  p_burst_group_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && advance && brst_act) |=>
      (acc_valid && acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

endmodule

// File: rtl/ftb_wreg.sv
module ftb_wreg #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             cap_valid,
  input  logic [AW-1:0]    cap_addr,
  input  logic [NL-1:0]    cap_be,
  input  logic [NL*LW-1:0] wdata,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NL*LW-1:0] rd_word,
  output logic             commit,
  output logic [AW-1:0]    commit_addr,
  output logic [NL-1:0]    commit_be,
  output logic [NL*LW-1:0] commit_data,
  output logic [NL*LW-1:0] fwd_word
);

  logic             pend_valid;
  logic [AW-1:0]    pend_addr;
  logic [NL-1:0]    pend_be;
  logic [NL*LW-1:0] pend_data;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_be    <= '0;
      pend_data  <= '0;
    end else if (clk_en) begin
      pend_valid <= cap_valid && (|cap_be);
      pend_addr  <= cap_addr;
      pend_be    <= cap_be;
      pend_data  <= wdata;
    end
  end

  assign commit      = clk_en && pend_valid && !rst;
  assign commit_addr = pend_addr;
  assign commit_be   = pend_be;
  assign commit_data = pend_data;
  assign hit         = pend_valid && (pend_addr == rd_addr);

  for (genvar l = 0; l < NL; l++) begin : g_fwd
    assign fwd_word[l*LW +: LW] = (hit && pend_be[l]) ? pend_data[l*LW +: LW]
                                                      : rd_word[l*LW +: LW];
  end

  // R6: an all-lanes-off write beat never becomes a pending commit
  p_abort_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && cap_valid && cap_be == '0) |=> !pend_valid);

endmodule

// File: rtl/ftb_array.sv
module ftb_array #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NL-1:0]    wbe,
  input  logic [NL*LW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NL*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[l]) mem[waddr] <= wdata[l*LW +: LW];
    end

    assign rdata[l*LW +: LW] = mem[raddr];
  end

endmodule

// File: rtl/ftburst_sram.sv
module ftburst_sram
  import ftb_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int NUM_SEL = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic [NUM_SEL-1:0]      chip_sel,
  input  logic                    advance,
  input  logic                    write,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        byte_en,
  input  logic                    interleave,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_oe
);

  localparam int DW = LANES * LANE_W;

  logic              sel_ok;
  logic              acc_valid;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_be;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_be;
  logic [DW-1:0]     commit_data;
  logic [DW-1:0]     arr_word;
  logic [DW-1:0]     fwd_word;

  assign sel_ok = &chip_sel;

  ftb_ctl #(.AW(ADDR_W), .NL(LANES)) i_ctl (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep), .sel_ok(sel_ok),
    .advance(advance), .we(write), .interleave(interleave), .addr(addr),
    .byte_en(byte_en), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_be(acc_be)
  );

  ftb_wreg #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) i_wreg (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .cap_valid(acc_valid && acc_we), .cap_addr(acc_addr), .cap_be(acc_be),
    .wdata(wdata), .rd_addr(acc_addr), .rd_word(arr_word),
    .commit(commit), .commit_addr(commit_addr), .commit_be(commit_be),
    .commit_data(commit_data), .fwd_word(fwd_word)
  );

  ftb_array #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) i_array (
    .clk(clk), .we(commit), .waddr(commit_addr), .wbe(commit_be),
    .wdata(commit_data), .raddr(acc_addr), .rdata(arr_word)
  );

  assign q_oe = acc_valid && !acc_we && oe && !sleep;
  assign q    = q_oe ? fwd_word : '0;

  // R9: a deselecting load cycle releases the data pins after the edge
  p_deselect_hiz_r9: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && !advance && !sel_ok) |=> !q_oe);

  // R11: the pins are released on the first cycle after sleep ends
  p_sleep_exit_hiz_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> !q_oe);

endmodule

// File: tb/test_ftburst_sram.sv
module test_ftburst_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke = 1'b1;
  logic [2:0]    sel = 3'b111;
  logic          adv = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] be = '0;
  logic          il = 1'b0;
  logic          oe = 1'b1;
  logic          slp = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] q;
  logic          q_oe;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R12";

  ftburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .NUM_SEL(3)) i_ftburst_sram (
    .clk(clk), .rst(rst), .clk_en(cke), .chip_sel(sel), .advance(adv),
    .write(we), .addr(addr), .byte_en(be), .interleave(il), .oe(oe),
    .sleep(slp), .wdata(wdata), .q(q), .q_oe(q_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: memory, burst state and last accepted access.
  logic [DW-1:0] mdl [64];
  int m_act = 0, m_we = 0, m_base = 0, m_cnt = 0, m_il = 0;
  int m_v = 0, m_w = 0, m_a = 0;
  logic [NL-1:0] m_be = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0;
      m_v   = 0;
    end else begin
      if (cke && m_v != 0 && m_w != 0)
        for (int l = 0; l < NL; l++)
          if (m_be[l]) mdl[m_a][l*LW +: LW] = wdata[l*LW +: LW];
      if (slp) begin
        m_act = 0;
        m_v   = 0;
      end else if (cke) begin
        if (!adv) begin
          if (sel == 3'b111) begin
            m_act = 1; m_we = int'(we); m_base = int'(addr); m_cnt = 0; m_il = int'(il);
            m_v = 1; m_w = m_we; m_a = m_base; m_be = be;
          end else begin
            m_act = 0;
            m_v   = 0;
          end
        end else if (m_act != 0) begin
          int lo;
          m_cnt = (m_cnt + 1) % 4;
          lo = (m_il != 0) ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4);
          m_a = (m_base / 4) * 4 + lo;
          m_v = 1; m_w = m_we; m_be = be;
        end else begin
          m_v = 0;
        end
      end
    end
  end

  task automatic compare();
    logic          e_oe;
    logic [DW-1:0] e_q;
    e_oe = (m_v != 0) && (m_w == 0) && oe && !slp;
    e_q  = e_oe ? mdl[m_a] : '0;
    vectors++;
    if (q_oe !== e_oe || q !== e_q) begin
      miscompares++;
      $display("FAIL %s: q_oe=%b q=%h expected q_oe=%b q=%h", cur_req, q_oe, q, e_oe, e_q);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic cyc(input logic a_adv, input logic a_we, input int a_addr,
                     input logic [NL-1:0] a_be);
    adv  = a_adv;
    we   = a_we;
    addr = AW'(a_addr);
    be   = a_be;
    tick();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    logic [8:0] b;
    b = 9'(a);
    return {b ^ 9'h155, b + 9'd3, ~b, b + 9'd77};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R12: reset leaves outputs released
    cur_req = "R12";
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R5: fill every word through linear write bursts, data one edge late
    cur_req = "R5";
    for (int k = 0; k < 64; k++) begin
      wdata = (k > 0) ? pat(k - 1) : '0;
      cyc((k % 4) != 0, 1'b1, k, 4'hF);
    end
    wdata = pat(63);
    sel = 3'b011;
    cyc(1'b0, 1'b0, 0, 4'h0);
    sel = 3'b111;

    // R2/R3/R4: linear read burst from 6 wraps 6,7,4,5,6
    cur_req = "R2/R3/R4";
    cyc(1'b0, 1'b0, 6, 4'h0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 0, 4'h0);

    // R3: interleaved read burst from 9 gives 9,8,11,10
    cur_req = "R3";
    il = 1'b1;
    cyc(1'b0, 1'b0, 9, 4'h0);
    il = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 0, 4'h0);

    // R1/R7: alternating writes and reads, reads hit the pending write
    cur_req = "R1/R7";
    cyc(1'b0, 1'b1, 20, 4'hF);
    wdata = 36'hABCDEF012;
    cyc(1'b0, 1'b0, 20, 4'h0);
    cyc(1'b0, 1'b1, 21, 4'b0101);
    wdata = 36'h123456789;
    cyc(1'b0, 1'b0, 21, 4'h0);
    cyc(1'b0, 1'b1, 22, 4'hF);
    wdata = 36'h0F0F0F0F0;
    cyc(1'b0, 1'b1, 22, 4'b1000);
    wdata = 36'hFFFFFFFFF;
    cyc(1'b0, 1'b0, 22, 4'h0);
    cyc(1'b0, 1'b0, 21, 4'h0);

    // R6: abort at burst start and in mid-burst
    cur_req = "R6";
    cyc(1'b0, 1'b1, 40, 4'h0);
    wdata = 36'h555555555;
    cyc(1'b0, 1'b0, 40, 4'h0);
    cyc(1'b0, 1'b1, 44, 4'hF);
    wdata = 36'h111111111;
    cyc(1'b1, 1'b1, 0, 4'h0);
    wdata = 36'h222222222;
    cyc(1'b1, 1'b1, 0, 4'hF);
    wdata = 36'h333333333;
    cyc(1'b1, 1'b1, 0, 4'b0010);
    wdata = 36'h444444444;
    cyc(1'b0, 1'b0, 44, 4'h0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 0, 4'h0);

    // R8: stall holds a read and delays write data sampling
    cur_req = "R8";
    cyc(1'b0, 1'b0, 12, 4'h0);
    cke = 1'b0;
    cyc(1'b0, 1'b1, 50, 4'hF);
    cyc(1'b1, 1'b0, 0, 4'h0);
    cke = 1'b1;
    cyc(1'b1, 1'b0, 0, 4'h0);
    cyc(1'b0, 1'b1, 13, 4'hF);
    cke = 1'b0;
    wdata = 36'hDEADBEEF0;
    cyc(1'b0, 1'b0, 0, 4'h0);
    cke = 1'b1;
    wdata = 36'h876543210;
    cyc(1'b0, 1'b0, 13, 4'h0);

    // R10: output enable releases pins without a clock edge
    cur_req = "R10";
    cyc(1'b0, 1'b0, 30, 4'h0);
    oe = 1'b0;
    #1;
    compare();
    cyc(1'b1, 1'b0, 0, 4'h0);
    oe = 1'b1;
    #1;
    compare();

    // R9: deselect on load, advance stays deselected
    cur_req = "R9";
    cyc(1'b0, 1'b0, 31, 4'h0);
    sel = 3'b110;
    cyc(1'b0, 1'b0, 32, 4'h0);
    sel = 3'b111;
    cyc(1'b1, 1'b0, 0, 4'h0);
    cyc(1'b0, 1'b0, 33, 4'h0);

    // R11: sleep after deselect, pins stay released on exit
    cur_req = "R11";
    sel = 3'b101;
    cyc(1'b0, 1'b0, 0, 4'h0);
    sel = 3'b111;
    slp = 1'b1;
    cyc(1'b0, 1'b0, 5, 4'h0);
    cke = 1'b0;
    cyc(1'b0, 1'b0, 6, 4'h0);
    cke = 1'b1;
    cyc(1'b0, 1'b0, 7, 4'h0);
    slp = 1'b0;
    cyc(1'b1, 1'b0, 0, 4'h0);
    cyc(1'b0, 1'b0, 5, 4'h0);
    cyc(1'b1, 1'b0, 0, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule